// File: doc/BRIEF.md
# Quasi-Bidirectional Open-Drain Port Group

This block is a register-mapped group of three ports on a simple CPU register bus. Port A is eight lines wide. Each line is an open-drain output with a pull-up: an output latch bit of 0 turns on a pull-down, and a latch bit of 1 releases the line. A released line can then be read as an input. Port B has the same structure on its two lowest lines, and its upper six lines are inputs only. Port C is a single push-pull output bit. Pad electrical behaviour is reduced to a logic pad level per line and a pull-down enable per line. Software must write a 1 to a line before it can read an external level on that line.

Reads return the live pad levels, sampled on the clock edge that accepts the read, and are not taken from the output latches. A pad can only read high when its latch also holds 1. The output latches change only when they are written. Bit-set, bit-clear and bit-complement operations read the whole port view, change the one addressed bit and write the result back into the latch. This means another line that is held low from outside gets its latch cleared as a side effect. These operations run through a small state machine. Its states are ST_IDLE (accepts a bus request), ST_FETCH (captures the port view) and ST_APPLY (writes the modified value back). The transitions are: ST_IDLE to ST_FETCH when a bit operation hits a port, ST_FETCH to ST_APPLY always, and ST_APPLY to ST_IDLE always.

A wake-up request is raised while the device is halted and any port B line selected by a static mask reads low.

Top module: `qbio_port_bank`

## Requirements
- R1: Port A decodes at address 0x12, port B at 0x14 and port C at 0x16. A read of any other address returns 0x00, and a write to any other address changes no latch.
- R2: After reset every output latch holds 1. No pull-down is enabled, `pc_out` is 1 and `busy` and `wake_req` are 0.
- R3: A byte write (`op` = 0) to port A loads the latch on the accepting edge. `pa_pull_dn[i]` is then the inverse of latch bit i.
- R4: `rdata` is registered and is valid the cycle after `rd_en`. For port A it equals pad AND latch, sampled on the accepting edge.
- R5: Port B lines 0–1 behave like port A lines (latch, pull-down, pad AND latch). Lines 2–7 read their pad directly, have no latch, and written values for them are ignored.
- R6: Port C output follows bit 0 of the last write. A port C read returns {7'b0, latch}, and bits 7:1 of any write to port C are ignored.
- R7: A latch keeps its value while no write targets its port, even when the pads change.
- R8: `op` = 1 sets, 2 clears and 3 complements the bit indexed by `wdata[2:0]`. The bit operation uses the port view captured in ST_FETCH and writes the latch in ST_APPLY. `busy` is high for exactly the two cycles after the accepting edge.
- R9: A bus write presented while `busy` is high is ignored.
- R10: `wake_req` is registered. It becomes 1 one edge after `halt` is high and a port B line whose `WAKE_MASK` bit is 1 reads low. Lines with a mask bit of 0 never raise it.
- R11: `wake_req` returns to 0 one edge after `halt` drops or after all enabled lines read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW (8) | Register address |
| wdata | input | DW (8) | Write data; bits 2:0 give the bit index for bit operations |
| op | input | 2 | 0 byte write, 1 set bit, 2 clear bit, 3 complement bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | DW (8) | Registered read data |
| busy | output | 1 | Bit operation in progress |
| pa_pad | input | DW (8) | Port A pad levels |
| pa_pull_dn | output | DW (8) | Port A pull-down enables |
| pb_pad | input | DW (8) | Port B pad levels |
| pb_pull_dn | output | PB_IO (2) | Port B lines 0–1 pull-down enables |
| pc_out | output | 1 | Port C output level |
| halt | input | 1 | Device halted |
| wake_req | output | 1 | Wake-up request |

## Verification
On every cycle, the assertions check these properties: the reset values of the latches, that latches stay stable when no write targets them, the fixed ST_FETCH to ST_APPLY to ST_IDLE sequence, that no latch write happens during capture, that a read never returns 1 where the latch drives 0, the zero upper bits of port C, and how the wake request follows `halt`. Some behaviour needs a specific sequence of pad levels, and only the bench scenarios can show it. These cases are: the read-modify-write side effect on a line held low from outside, live pad sampling after the latch is released, input-only lines of port B ignoring writes, and a byte write lost while a bit operation is busy.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_FLIP  = 2'd3
    } qbio_op_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_A    = 2'd1,
        SEL_B    = 2'd2,
        SEL_C    = 2'd3
    } qbio_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_APPLY = 2'd2
    } qbio_state_e;

endpackage

// File: rtl/qbio_latch_bank.sv
module qbio_latch_bank
    import qbio_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PB_IO = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  qbio_sel_e        sel,
    input  logic [DW-1:0]    data,
    output logic [DW-1:0]    pa_q,
    output logic [PB_IO-1:0] pb_q,
    output logic             pc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q <= '1;
            pb_q <= '1;
            pc_q <= 1'b1;
        end else if (we) begin
            case (sel)
                SEL_A:   pa_q <= data;
                SEL_B:   pb_q <= data[PB_IO-1:0];
                SEL_C:   pc_q <= data[0];
                default: ;
            endcase
        end
    end

    // R2
    reset_ones_chk: assert property (@(posedge clk)
        rst |=> (pa_q == '1) && (pb_q == '1) && pc_q);

    // R3
    pa_load_chk: assert property (@(posedge clk) disable iff (rst)
        (we && sel == SEL_A) |=> pa_q == $past(data));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!we || sel == SEL_NONE) |=> $stable(pa_q) && $stable(pb_q) && $stable(pc_q));

endmodule

// File: rtl/qbio_port_view.sv
module qbio_port_view
    import qbio_pkg::*;
#(
    parameter int DW    = 8,
    parameter int PB_IO = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  qbio_sel_e        sel,
    input  logic [DW-1:0]    pa_pad,
    input  logic [DW-1:0]    pb_pad,
    input  logic [DW-1:0]    pa_q,
    input  logic [PB_IO-1:0] pb_q,
    input  logic             pc_q,
    output logic [DW-1:0]    pa_view,
    output logic [DW-1:0]    pb_view,
    output logic [DW-1:0]    pc_view,
    output logic [DW-1:0]    rdata
);

    always_comb begin
        pa_view = pa_pad & pa_q;
        pb_view = {pb_pad[DW-1:PB_IO], pb_pad[PB_IO-1:0] & pb_q};
        pc_view = {{(DW-1){1'b0}}, pc_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_A:   rdata <= pa_view;
                SEL_B:   rdata <= pb_view;
                SEL_C:   rdata <= pc_view;
                default: rdata <= '0;
            endcase
        end
    end

    // R1
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_NONE) |=> rdata == '0);

    // R4
    pa_no_false_high_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_A) |=> (rdata & ~$past(pa_q)) == '0);

    // R6
    pc_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_C) |=> rdata[DW-1:1] == '0);

endmodule

// File: rtl/qbio_rmw_fsm.sv
module qbio_rmw_fsm
    import qbio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  qbio_op_e      op,
    input  qbio_sel_e     sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pa_view,
    input  logic [DW-1:0] pb_view,
    input  logic [DW-1:0] pc_view,
    output logic          lat_we,
    output qbio_sel_e     lat_sel,
    output logic [DW-1:0] lat_data,
    output logic          busy
);

    localparam int IW = $clog2(DW);

    qbio_state_e   state, state_nx;
    qbio_sel_e     tgt_sel;
    qbio_op_e      tgt_op;
    logic [IW-1:0] tgt_idx;
    logic [DW-1:0] snap;
    logic [DW-1:0] bit_mask;
    logic [DW-1:0] modified;
    logic          accept_bitop;

    assign accept_bitop = wr_en && (sel != SEL_NONE) && (op != OP_WRITE);

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept_bitop) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_APPLY;
            ST_APPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_sel <= SEL_NONE;
            tgt_op  <= OP_WRITE;
            tgt_idx <= '0;
            snap    <= '0;
        end else begin
            if (state == ST_IDLE && accept_bitop) begin
                tgt_sel <= sel;
                tgt_op  <= op;
                tgt_idx <= wdata[IW-1:0];
            end
            if (state == ST_FETCH) begin
                case (tgt_sel)
                    SEL_A:   snap <= pa_view;
                    SEL_B:   snap <= pb_view;
                    SEL_C:   snap <= pc_view;
                    default: snap <= '0;
                endcase
            end
        end
    end

    always_comb begin
        bit_mask = {{(DW-1){1'b0}}, 1'b1} << tgt_idx;
        case (tgt_op)
            OP_SET:  modified = snap | bit_mask;
            OP_CLR:  modified = snap & ~bit_mask;
            OP_FLIP: modified = snap ^ bit_mask;
            default: modified = snap;
        endcase
    end

    always_comb begin
        lat_we   = 1'b0;
        lat_sel  = SEL_NONE;
        lat_data = '0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (wr_en && op == OP_WRITE && sel != SEL_NONE) begin
                    lat_we   = 1'b1;
                    lat_sel  = sel;
                    lat_data = wdata;
                end
            end
            ST_FETCH: ;
            ST_APPLY: begin
                lat_we   = 1'b1;
                lat_sel  = tgt_sel;
                lat_data = modified;
            end
            default: ;
        endcase
    end

    // R8
    fetch_to_apply_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |=> state == ST_APPLY);

    // R8
    apply_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_APPLY |=> state == ST_IDLE);

    // R9
    no_write_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_FETCH |-> !lat_we);

    // R9
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> state != ST_FETCH);

endmodule

// File: rtl/qbio_wake_gen.sv
module qbio_wake_gen #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] WAKE_MASK = 8'h84
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          halt,
    input  logic [DW-1:0] pb_view,
    output logic          wake_req
);

    logic any_low;
    assign any_low = |(WAKE_MASK & ~pb_view);

    always_ff @(posedge clk) begin
        if (rst) wake_req <= 1'b0;
        else     wake_req <= halt && any_low;
    end

    // R11
    wake_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !halt |=> !wake_req);

    // R10
    wake_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (halt && ((pb_view & WAKE_MASK) != WAKE_MASK)) |=> wake_req);

endmodule

// File: rtl/qbio_port_bank.sv
module qbio_port_bank
    import qbio_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter int            PB_IO     = 2,
    parameter logic [AW-1:0] PA_ADDR   = 8'h12,
    parameter logic [AW-1:0] PB_ADDR   = 8'h14,
    parameter logic [AW-1:0] PC_ADDR   = 8'h16,
    parameter logic [DW-1:0] WAKE_MASK = 8'h84
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [1:0]       op,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [DW-1:0]    rdata,
    output logic             busy,
    input  logic [DW-1:0]    pa_pad,
    output logic [DW-1:0]    pa_pull_dn,
    input  logic [DW-1:0]    pb_pad,
    output logic [PB_IO-1:0] pb_pull_dn,
    output logic             pc_out,
    input  logic             halt,
    output logic             wake_req
);

    qbio_sel_e       sel;
    qbio_sel_e       lat_sel;
    logic            lat_we;
    logic [DW-1:0]   lat_data;
    logic [DW-1:0]   pa_q;
    logic [PB_IO-1:0] pb_q;
    logic            pc_q;
    logic [DW-1:0]   pa_view, pb_view, pc_view;

    always_comb begin
        sel = SEL_NONE;
        if      (addr == PA_ADDR) sel = SEL_A;
        else if (addr == PB_ADDR) sel = SEL_B;
        else if (addr == PC_ADDR) sel = SEL_C;
    end

    qbio_rmw_fsm #(.DW(DW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .op       (qbio_op_e'(op)),
        .sel      (sel),
        .wdata    (wdata),
        .pa_view  (pa_view),
        .pb_view  (pb_view),
        .pc_view  (pc_view),
        .lat_we   (lat_we),
        .lat_sel  (lat_sel),
        .lat_data (lat_data),
        .busy     (busy)
    );

    qbio_latch_bank #(.DW(DW), .PB_IO(PB_IO)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .we   (lat_we),
        .sel  (lat_sel),
        .data (lat_data),
        .pa_q (pa_q),
        .pb_q (pb_q),
        .pc_q (pc_q)
    );

    qbio_port_view #(.DW(DW), .PB_IO(PB_IO)) u_view (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .sel     (sel),
        .pa_pad  (pa_pad),
        .pb_pad  (pb_pad),
        .pa_q    (pa_q),
        .pb_q    (pb_q),
        .pc_q    (pc_q),
        .pa_view (pa_view),
        .pb_view (pb_view),
        .pc_view (pc_view),
        .rdata   (rdata)
    );

    qbio_wake_gen #(.DW(DW), .WAKE_MASK(WAKE_MASK)) u_wake (
        .clk      (clk),
        .rst      (rst),
        .halt     (halt),
        .pb_view  (pb_view),
        .wake_req (wake_req)
    );

    assign pa_pull_dn = ~pa_q;
    assign pb_pull_dn = ~pb_q;
    assign pc_out     = pc_q;

endmodule

// File: tb/qbio_port_bank_test.sv
`timescale 1ns/1ps
module qbio_port_bank_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0, wdata = '0;
    logic [1:0] op = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, halt = 1'b0;
    logic [7:0] rdata;
    logic       busy, pc_out, wake_req;
    logic [7:0] pa_pull_dn;
    logic [1:0] pb_pull_dn;
    logic [7:0] ext_a = 8'hFF, ext_b = 8'hFF;
    logic [7:0] pa_pad, pb_pad;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic rd_seen = 1'b0;
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #10 clk = ~clk;

    // pad model: external level wired-AND with the pull-down
    assign pa_pad = ext_a & ~pa_pull_dn;
    assign pb_pad = {ext_b[7:2], ext_b[1:0] & ~pb_pull_dn};

    qbio_port_bank uut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .op(op),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .busy(busy),
        .pa_pad(pa_pad), .pa_pull_dn(pa_pull_dn), .pb_pad(pb_pad),
        .pb_pull_dn(pb_pull_dn), .pc_out(pc_out), .halt(halt),
        .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    // monitor: compares registered read data against the scoreboard
    always @(negedge clk) begin
        if (rd_seen) begin
            if (q_exp.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4 unexpected read actual=%0h expected=none", rdata);
            end else begin
                automatic logic [7:0] e = q_exp.pop_front();
                automatic string t = q_tag.pop_front();
                chk(t, 32'(rdata), 32'(e));
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d, input logic [1:0] o);
        @(negedge clk);
        addr = a; wdata = d; op = o; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (o != 2'd0) repeat (2) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        chk("R2 pa_pull_dn", 32'(pa_pull_dn), 32'h00);
        chk("R2 pb_pull_dn", 32'(pb_pull_dn), 32'h0);
        chk("R2 pc_out", 32'(pc_out), 32'h1);
        chk("R2 busy", 32'(busy), 32'h0);
        chk("R2 wake_req", 32'(wake_req), 32'h0);
        bus_rd(8'h12, 8'hFF, "R2 read A");
        bus_rd(8'h14, 8'hFF, "R2 read B");
        bus_rd(8'h16, 8'h01, "R6 read C after reset");

        // R3 byte write to port A drives pull-downs
        bus_wr(8'h12, 8'h5A, 2'd0);
        chk("R3 pa_pull_dn", 32'(pa_pull_dn), 32'hA5);
        bus_rd(8'h12, 8'h5A, "R4 read A pad AND latch");
        // R7 latch holds while pads change
        ext_a = 8'h00;
        settle();
        chk("R7 pa_pull_dn hold", 32'(pa_pull_dn), 32'hA5);
        bus_rd(8'h12, 8'h00, "R4 read A live low");
        // R4 released lines read external level
        bus_wr(8'h12, 8'hFF, 2'd0);
        ext_a = 8'h0F;
        bus_rd(8'h12, 8'h0F, "R4 read A external");

        // R8 read-modify-write with lines held low from outside
        ext_a = 8'hF0;
        bus_wr(8'h12, 8'h00, 2'd1);
        chk("R8 set bit0 side effect", 32'(pa_pull_dn), 32'h0E);
        ext_a = 8'hFF;
        bus_wr(8'h12, 8'h07, 2'd2);
        chk("R8 clear bit7", 32'(pa_pull_dn), 32'h8E);
        bus_wr(8'h12, 8'h01, 2'd3);
        chk("R8 complement bit1", 32'(pa_pull_dn), 32'h8C);
        bus_rd(8'h12, 8'h73, "R8 read A after bit ops");

        // R1 unmapped address
        bus_rd(8'h13, 8'h00, "R1 unmapped read");
        bus_wr(8'h13, 8'h00, 2'd0);
        chk("R1 unmapped write no effect", 32'(pa_pull_dn), 32'h8C);

        // R8 busy timing and R9 write ignored while busy
        bus_wr(8'h12, 8'hFF, 2'd0);
        @(negedge clk);
        addr = 8'h12; op = 2'd2; wdata = 8'h03; wr_en = 1'b1;
        @(negedge clk);
        chk("R8 busy cycle1", 32'(busy), 32'h1);
        op = 2'd0; wdata = 8'h00;
        @(negedge clk);
        chk("R8 busy cycle2", 32'(busy), 32'h1);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R8 busy released", 32'(busy), 32'h0);
        chk("R9 write during busy ignored", 32'(pa_pull_dn), 32'h08);

        // R5 port B
        ext_b = 8'hFF;
        bus_wr(8'h14, 8'h00, 2'd0);
        chk("R5 pb_pull_dn", 32'(pb_pull_dn), 32'h3);
        bus_rd(8'h14, 8'hFC, "R5 read B low lines pulled");
        bus_wr(8'h14, 8'hFF, 2'd0);
        chk("R5 pb released", 32'(pb_pull_dn), 32'h0);
        ext_b = 8'hA3;
        bus_wr(8'h14, 8'h03, 2'd0);
        bus_rd(8'h14, 8'hA3, "R5 input lines ignore write");

        // R6 port C
        bus_wr(8'h16, 8'h00, 2'd0);
        chk("R6 pc_out cleared", 32'(pc_out), 32'h0);
        bus_rd(8'h16, 8'h00, "R6 read C zero");
        bus_wr(8'h16, 8'hFE, 2'd0);
        chk("R6 upper bits ignored", 32'(pc_out), 32'h0);
        bus_wr(8'h16, 8'h01, 2'd0);
        chk("R6 pc_out set", 32'(pc_out), 32'h1);
        bus_wr(8'h16, 8'h05, 2'd1);
        chk("R6 set unimplemented bit", 32'(pc_out), 32'h1);
        bus_rd(8'h16, 8'h01, "R6 read C after set bit5");

        // R10 / R11 wake-up (mask bits 7 and 2)
        ext_b = 8'h7F; halt = 1'b0;
        settle();
        chk("R11 no wake when running", 32'(wake_req), 32'h0);
        halt = 1'b1;
        settle();
        chk("R10 wake on bit7 low", 32'(wake_req), 32'h1);
        ext_b = 8'hFF;
        settle();
        chk("R11 wake clears on high", 32'(wake_req), 32'h0);
        ext_b = 8'hF7;
        settle();
        chk("R10 unmasked line no wake", 32'(wake_req), 32'h0);
        ext_b = 8'hFB;
        settle();
        chk("R10 wake on bit2 low", 32'(wake_req), 32'h1);
        halt = 1'b0;
        settle();
        chk("R11 wake clears on run", 32'(wake_req), 32'h0);

        settle();
        if (q_exp.size() != 0) begin
            checks++; errors++;
            $display("FAIL R4 pending reads actual=%0d expected=0", q_exp.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule